// File: doc/BRIEF.md
# Call Frame and Interrupt Entry Sequencer

This block is the control-flow sequencer of a 32-bit processor core. It owns the instruction pointer, the stack pointer, the frame pointer, the condition flags, the privilege bit and the hardware interrupt enable. It runs the multi-cycle memory sequences for subroutine call and return, for software and hardware interrupt entry, and for interrupt return. Each step of a sequence moves one word through a valid/ready memory port. The stack grows downward by one word per push. A push writes to SP-4 and then lowers SP. A pop reads at SP and then raises SP.

An instruction decoder drives the command interface with an opcode and one argument: a target address, a new SP, a flag value or a vector index. `busy_o` is high while a sequence is in progress. Hardware interrupt lines are captured on their rising edge into a pending vector. When interrupts are enabled, the lowest-numbered pending line is served first. It enters through vector index `HW_VEC_BASE + n`. Interrupt entry reads a two-word vector entry at `EVT_BASE + 8*index`: the handler IP is in the first word and the handler SP is in the second. The block then switches to the handler stack, saves the interrupted SP and flags on that stack, and builds an ordinary call frame on top of them.

Top module: `frame_irq_seq`

## Requirements
- R1: After reset, IP, SP, FP and flags are 0, privileged is 1, the interrupt enable is 0 and busy is low.
- R2: CALL (op 4) sets IP to the argument and pushes the old IP to SP-4, then the old FP to SP-8. It then leaves FP and SP both equal to the entry SP minus 8. Every push writes to the current SP minus 4.
- R3: RET (op 5) reloads FP from the word at FP, reloads IP from the word at FP+4, and leaves SP at FP+8.
- R4: INT (op 6, vector index in the low argument bits) loads IP from the word at EVT_BASE+8*index and SP from the next word. On that new stack it pushes, in this order, the old SP, the flag word, the return IP and the old FP. FP then equals the final SP.
- R5: The flag word holds the flags in bits 3:0, privileged in bit 4 and the interrupt enable in bit 5; it is the value held before entry. Entry then sets privileged to 1 and the enable to 0.
- R6: RETINT (op 7) first undoes the call frame as RET does. It then pops the flag word, which restores flags, privileged and the enable, and finally pops SP.
- R7: IRQs raised while the enable is 0 are held pending and are not served. Once the enable is 1, every pending IRQ is served, lowest-numbered first.
- R8: A hardware IRQ on line n enters exactly as INT does, with vector index HW_VEC_BASE+n (16+n by default), and saves the IP current at entry as the return IP.
- R9: IDLE (op 10) keeps busy high and leaves all state unchanged until an IRQ is served. Execution then continues into that IRQ's entry.
- R10: A command presented while busy is high is ignored.
- R11: A memory request holds its address, direction and write data stable until ready. SP does not change while the request waits.
- R12: JUMP (op 1, IP=argument), SETSP (op 2), SETF (op 3, flags=argument bits 3:0), CLI (op 8) and STI (op 9) complete in one cycle with no memory request. NOP (op 0) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present; taken when busy_o is low |
| cmd_op_i | input | 4 | Command opcode |
| cmd_arg_i | input | XLEN | Target address, SP value, flag value or vector index |
| busy_o | output | 1 | Sequence in progress; commands are ignored |
| irq_i | input | NIRQ | Hardware interrupt lines, rising-edge captured |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | XLEN | Byte address of the word |
| mem_wdata_o | output | XLEN | Write data |
| mem_ready_i | input | 1 | Memory accepts or completes the request this cycle |
| mem_rdata_i | input | XLEN | Read data, valid with mem_ready_i |
| ip_o | output | XLEN | Instruction pointer |
| sp_o | output | XLEN | Stack pointer |
| fp_o | output | XLEN | Frame pointer |
| flags_o | output | FLAGW | Condition flags |
| priv_o | output | 1 | Privileged mode |
| ie_o | output | 1 | Hardware interrupt enable |

## Verification
The bench runs a long random mix of calls, returns, software interrupts, interrupt returns and single-cycle commands, with memory stalls that vary at random. A reference model compares every register and the whole stack memory. Unbalanced returns pop words that are unrelated to the frame being unwound, so an error in push order or pop order shows up quickly. Directed cases separate queueing from delivery: two IRQs are raised while disabled and then released, which exposes both the lowest-first order and the redelivery that follows the enable restored by RETINT. An idle wait is woken by a single IRQ. A command issued during a stalled call shows whether busy commands are truly dropped.

// File: rtl/fis_pkg.sv
package fis_pkg;

   typedef enum logic [3:0] {
      OP_NOP    = 4'd0,
      OP_JUMP   = 4'd1,
      OP_SETSP  = 4'd2,
      OP_SETF   = 4'd3,
      OP_CALL   = 4'd4,
      OP_RET    = 4'd5,
      OP_INT    = 4'd6,
      OP_RETINT = 4'd7,
      OP_CLI    = 4'd8,
      OP_STI    = 4'd9,
      OP_IDLE   = 4'd10
   } fis_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT,
      ST_VEC_IP,
      ST_VEC_SP,
      ST_PUSH_SP,
      ST_PUSH_FL,
      ST_PUSH_IP,
      ST_PUSH_FP,
      ST_POP_FP,
      ST_POP_IP,
      ST_POP_FL,
      ST_POP_SP
   } fis_state_e;

endpackage

// File: rtl/fis_irq_gate.sv
module fis_irq_gate #(
   parameter int NIRQ     = 8,
   parameter bit IRQ_EDGE = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NIRQ-1:0] irq_i,
   input  logic [NIRQ-1:0] clr_i,
   output logic [NIRQ-1:0] pend_o
);

   logic [NIRQ-1:0] raise;
   logic [NIRQ-1:0] pend_q;

   generate
      if (IRQ_EDGE) begin : g_edge
         logic [NIRQ-1:0] prev_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prev_q <= '0;
            else         prev_q <= irq_i;
         end
         assign raise = irq_i & ~prev_q;
      end else begin : g_level
         assign raise = irq_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= (pend_q & ~clr_i) | raise;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/fis_prio_pick.sv
module fis_prio_pick #(
   parameter int N  = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [N-1:0]  grant_o,
   output logic [IW-1:0] idx_o
);

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign grant_o[i]  = req_i[i] & ~seen[i];
         assign seen[i + 1] = seen[i] | req_i[i];
      end
   endgenerate

   assign any_o = seen[N];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (grant_o[i]) idx_o = idx_o | IW'(i);
      end
   end

endmodule

// File: rtl/frame_irq_seq.sv
module frame_irq_seq
   import fis_pkg::*;
#(
   parameter int                 XLEN        = 32,
   parameter int                 FLAGW       = 4,
   parameter int                 NIRQ        = 8,
   parameter int                 VIDX_W      = 6,
   parameter int                 HW_VEC_BASE = 16,
   parameter bit                 IRQ_EDGE    = 1'b1,
   parameter logic [XLEN-1:0]    EVT_BASE    = XLEN'(32'h0000_0100)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmd_valid_i,
   input  logic [3:0]       cmd_op_i,
   input  logic [XLEN-1:0]  cmd_arg_i,
   output logic             busy_o,
   input  logic [NIRQ-1:0]  irq_i,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic [XLEN-1:0]  mem_addr_o,
   output logic [XLEN-1:0]  mem_wdata_o,
   input  logic             mem_ready_i,
   input  logic [XLEN-1:0]  mem_rdata_i,
   output logic [XLEN-1:0]  ip_o,
   output logic [XLEN-1:0]  sp_o,
   output logic [XLEN-1:0]  fp_o,
   output logic [FLAGW-1:0] flags_o,
   output logic             priv_o,
   output logic             ie_o
);

   localparam int              WORD_BYTES = XLEN / 8;
   localparam logic [XLEN-1:0] STEP       = XLEN'(WORD_BYTES);
   localparam int              ENT_SHIFT  = $clog2(2 * WORD_BYTES);
   localparam int              IW         = (NIRQ > 1) ? $clog2(NIRQ) : 1;

   generate
      if (XLEN < 16 || (XLEN % 8) != 0) begin : g_bad_xlen
         $error("XLEN must be a multiple of 8 and at least 16");
      end
      if (NIRQ < 1) begin : g_bad_nirq
         $error("NIRQ must be at least 1");
      end
      if (FLAGW + 2 > XLEN) begin : g_bad_flagw
         $error("flag word does not fit in XLEN");
      end
      if (HW_VEC_BASE + NIRQ > (1 << VIDX_W)) begin : g_bad_vec
         $error("hardware vectors exceed the vector index range");
      end
   endgenerate

   fis_state_e        state_q;
   logic [XLEN-1:0]   ip_q, sp_q, fp_q, tmp_sp_q, link_ip_q;
   logic [FLAGW-1:0]  flags_q;
   logic              priv_q, ie_q, ret_int_q;
   logic [VIDX_W-1:0] vec_q;

   logic [NIRQ-1:0]   pend;
   logic [NIRQ-1:0]   pick_grant;
   logic [IW-1:0]     pick_idx;
   logic              pick_any;
   logic              irq_take;
   logic              at_rest;
   logic [XLEN-1:0]   evt_addr;
   logic [XLEN-1:0]   flag_word;
   logic [XLEN-1:0]   sp_dec;
   fis_op_e           op;

   fis_irq_gate #(.NIRQ(NIRQ), .IRQ_EDGE(IRQ_EDGE)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .irq_i  (irq_i),
      .clr_i  (irq_take ? pick_grant : '0),
      .pend_o (pend)
   );

   fis_prio_pick #(.N(NIRQ)) u_pick (
      .req_i   (pend),
      .any_o   (pick_any),
      .grant_o (pick_grant),
      .idx_o   (pick_idx)
   );

   assign op        = fis_op_e'(cmd_op_i);
   assign at_rest   = (state_q == ST_IDLE) || (state_q == ST_WAIT);
   assign irq_take  = ie_q && pick_any && at_rest;
   assign busy_o    = !(state_q == ST_IDLE) || irq_take;
   assign evt_addr  = EVT_BASE + (XLEN'(vec_q) << ENT_SHIFT);
   assign flag_word = XLEN'({ie_q, priv_q, flags_q});
   assign sp_dec    = sp_q - STEP;

   always_comb begin
      mem_req_o   = 1'b1;
      mem_we_o    = 1'b0;
      mem_addr_o  = sp_q;
      mem_wdata_o = '0;
      unique case (state_q)
         ST_VEC_IP:  mem_addr_o = evt_addr;
         ST_VEC_SP:  mem_addr_o = evt_addr + STEP;
         ST_PUSH_SP: begin mem_we_o = 1'b1; mem_addr_o = sp_dec; mem_wdata_o = tmp_sp_q;  end
         ST_PUSH_FL: begin mem_we_o = 1'b1; mem_addr_o = sp_dec; mem_wdata_o = flag_word; end
         ST_PUSH_IP: begin mem_we_o = 1'b1; mem_addr_o = sp_dec; mem_wdata_o = link_ip_q; end
         ST_PUSH_FP: begin mem_we_o = 1'b1; mem_addr_o = sp_dec; mem_wdata_o = fp_q;      end
         ST_POP_FP:  mem_addr_o = fp_q;
         ST_POP_IP, ST_POP_FL, ST_POP_SP: mem_addr_o = sp_q;
         default:    mem_req_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         ip_q      <= '0;
         sp_q      <= '0;
         fp_q      <= '0;
         tmp_sp_q  <= '0;
         link_ip_q <= '0;
         flags_q   <= '0;
         priv_q    <= 1'b1;
         ie_q      <= 1'b0;
         ret_int_q <= 1'b0;
         vec_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_WAIT: begin
               if (irq_take) begin
                  tmp_sp_q  <= sp_q;
                  link_ip_q <= ip_q;
                  vec_q     <= VIDX_W'(HW_VEC_BASE) + VIDX_W'(pick_idx);
                  state_q   <= ST_VEC_IP;
               end else if (state_q == ST_IDLE && cmd_valid_i) begin
                  unique case (op)
                     OP_JUMP:  ip_q    <= cmd_arg_i;
                     OP_SETSP: sp_q    <= cmd_arg_i;
                     OP_SETF:  flags_q <= cmd_arg_i[FLAGW-1:0];
                     OP_CALL: begin
                        link_ip_q <= ip_q;
                        ip_q      <= cmd_arg_i;
                        state_q   <= ST_PUSH_IP;
                     end
                     OP_RET: begin
                        ret_int_q <= 1'b0;
                        state_q   <= ST_POP_FP;
                     end
                     OP_INT: begin
                        tmp_sp_q  <= sp_q;
                        link_ip_q <= ip_q;
                        vec_q     <= cmd_arg_i[VIDX_W-1:0];
                        state_q   <= ST_VEC_IP;
                     end
                     OP_RETINT: begin
                        ret_int_q <= 1'b1;
                        state_q   <= ST_POP_FP;
                     end
                     OP_CLI:  ie_q    <= 1'b0;
                     OP_STI:  ie_q    <= 1'b1;
                     OP_IDLE: state_q <= ST_WAIT;
                     default: ;
                  endcase
               end
            end
            default: begin
               if (mem_ready_i) begin
                  unique case (state_q)
                     ST_VEC_IP: begin
                        ip_q    <= mem_rdata_i;
                        state_q <= ST_VEC_SP;
                     end
                     ST_VEC_SP: begin
                        sp_q    <= mem_rdata_i;
                        state_q <= ST_PUSH_SP;
                     end
                     ST_PUSH_SP: begin
                        sp_q    <= sp_dec;
                        state_q <= ST_PUSH_FL;
                     end
                     ST_PUSH_FL: begin
                        sp_q    <= sp_dec;
                        priv_q  <= 1'b1;
                        ie_q    <= 1'b0;
                        state_q <= ST_PUSH_IP;
                     end
                     ST_PUSH_IP: begin
                        sp_q    <= sp_dec;
                        state_q <= ST_PUSH_FP;
                     end
                     ST_PUSH_FP: begin
                        sp_q    <= sp_dec;
                        fp_q    <= sp_dec;
                        state_q <= ST_IDLE;
                     end
                     ST_POP_FP: begin
                        fp_q    <= mem_rdata_i;
                        sp_q    <= fp_q + STEP;
                        state_q <= ST_POP_IP;
                     end
                     ST_POP_IP: begin
                        ip_q    <= mem_rdata_i;
                        sp_q    <= sp_q + STEP;
                        state_q <= ret_int_q ? ST_POP_FL : ST_IDLE;
                     end
                     ST_POP_FL: begin
                        flags_q <= mem_rdata_i[FLAGW-1:0];
                        priv_q  <= mem_rdata_i[FLAGW];
                        ie_q    <= mem_rdata_i[FLAGW+1];
                        sp_q    <= sp_q + STEP;
                        state_q <= ST_POP_SP;
                     end
                     ST_POP_SP: begin
                        sp_q    <= mem_rdata_i;
                        state_q <= ST_IDLE;
                     end
                     default: state_q <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   assign ip_o    = ip_q;
   assign sp_o    = sp_q;
   assign fp_o    = fp_q;
   assign flags_o = flags_q;
   assign priv_o  = priv_q;
   assign ie_o    = ie_q;

endmodule

// File: rtl/fis_checker.sv
module fis_checker #(
   parameter int XLEN = 32,
   parameter int NIRQ = 8
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            busy_o,
   input logic            mem_req_o,
   input logic            mem_we_o,
   input logic [XLEN-1:0] mem_addr_o,
   input logic [XLEN-1:0] mem_wdata_o,
   input logic            mem_ready_i,
   input logic [XLEN-1:0] sp_o,
   input logic [NIRQ-1:0] grant_i
);

   assert_req_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

   assert_sp_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ready_i) |=> $stable(sp_o));

   assert_quiet_at_rest_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !mem_req_o);

   assert_push_below_sp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_we_o) |-> (mem_addr_o == sp_o - XLEN'(XLEN / 8)));

   assert_single_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_i));

endmodule

bind frame_irq_seq fis_checker #(.XLEN(XLEN), .NIRQ(NIRQ)) u_fis_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .busy_o      (busy_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_ready_i (mem_ready_i),
   .sp_o        (sp_o),
   .grant_i     (pick_grant)
);

// File: tb/frame_irq_seq_tb_top.sv
module frame_irq_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] C_NOP = 4'd0, C_JUMP = 4'd1, C_SETSP = 4'd2, C_SETF = 4'd3,
                          C_CALL = 4'd4, C_RET = 4'd5, C_INT = 4'd6, C_RETINT = 4'd7,
                          C_CLI = 4'd8, C_STI = 4'd9, C_IDLE = 4'd10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic [31:0] cmd_arg = '0;
   logic        busy;
   logic [7:0]  irq = '0;
   logic        mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [31:0] ip, sp, fp;
   logic [3:0]  flags;
   logic        priv, ie;
   logic        hold_ready = 1'b0;

   logic [31:0] mem [1024];
   logic [31:0] mm  [1024];

   logic [31:0] m_ip, m_sp, m_fp;
   logic [3:0]  m_fl;
   logic        m_priv, m_ie;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   frame_irq_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_arg_i(cmd_arg), .busy_o(busy),
      .irq_i(irq),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
      .ip_o(ip), .sp_o(sp), .fp_o(fp), .flags_o(flags), .priv_o(priv), .ie_o(ie)
   );

   assign mem_rdata = mem[mem_addr[11:2]];

   always @(posedge clk) begin
      if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;
   end

   initial begin
      mem_ready = 1'b0;
      forever begin
         @(negedge clk);
         mem_ready = hold_ready ? 1'b0 : (($urandom % 3) != 0);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare_all(input string req);
      chk({req, " ip"}, ip, m_ip);
      chk({req, " sp"}, sp, m_sp);
      chk({req, " fp"}, fp, m_fp);
      chk({req, " flags"}, 32'(flags), 32'(m_fl));
      chk({req, " priv"}, 32'(priv), 32'(m_priv));
      chk({req, " ie"}, 32'(ie), 32'(m_ie));
   endtask

   task automatic m_push(input logic [31:0] v);
      m_sp = m_sp - 32'd4;
      mm[m_sp[11:2]] = v;
   endtask

   task automatic m_pop(output logic [31:0] v);
      v = mm[m_sp[11:2]];
      m_sp = m_sp + 32'd4;
   endtask

   task automatic m_entry(input int idx);
      logic [31:0] tsp, tip, ea;
      tsp = m_sp;
      tip = m_ip;
      ea  = 32'h100 + 32'(idx) * 32'd8;
      m_ip = mm[ea[11:2]];
      m_sp = mm[ea[11:2] + 10'd1];
      m_push(tsp);
      m_push({26'd0, m_ie, m_priv, m_fl});
      m_push(tip);
      m_push(m_fp);
      m_fp   = m_sp;
      m_priv = 1'b1;
      m_ie   = 1'b0;
   endtask

   task automatic m_unframe();
      logic [31:0] v;
      m_sp = m_fp;
      m_pop(v); m_fp = v;
      m_pop(v); m_ip = v;
   endtask

   task automatic m_apply(input logic [3:0] op, input logic [31:0] arg);
      logic [31:0] v;
      case (op)
         C_JUMP:  m_ip = arg;
         C_SETSP: m_sp = arg;
         C_SETF:  m_fl = arg[3:0];
         C_CALL: begin
            m_push(m_ip);
            m_ip = arg;
            m_push(m_fp);
            m_fp = m_sp;
         end
         C_RET: m_unframe();
         C_INT: m_entry(int'(arg[5:0]));
         C_RETINT: begin
            m_unframe();
            m_pop(v);
            m_fl = v[3:0]; m_priv = v[4]; m_ie = v[5];
            m_pop(v);
            m_sp = v;
         end
         C_CLI: m_ie = 1'b0;
         C_STI: m_ie = 1'b1;
         default: ;
      endcase
   endtask

   task automatic do_cmd(input logic [3:0] op, input logic [31:0] arg);
      while (busy) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int          mism;
      logic [31:0] ev;
      void'($urandom(32'h1F2E3D4C));
      for (int i = 0; i < 1024; i++) begin
         mem[i] <= 32'd0;
         mm[i]  = 32'd0;
      end
      for (int k = 0; k < 24; k++) begin
         if (k < 8 || k >= 16) begin
            mem[(32'h100 + k * 8) / 4]     <= 32'h4000 + 32'(k) * 32'd16;
            mem[(32'h100 + k * 8) / 4 + 1] <= 32'h0A00 - 32'(k) * 32'h20;
            mm[(32'h100 + k * 8) / 4]      = 32'h4000 + 32'(k) * 32'd16;
            mm[(32'h100 + k * 8) / 4 + 1]  = 32'h0A00 - 32'(k) * 32'h20;
         end
      end
      m_ip = 0; m_sp = 0; m_fp = 0; m_fl = 0; m_priv = 1'b1; m_ie = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      compare_all("R1");
      chk("R1 busy", 32'(busy), 32'd0);

      // R12: single-cycle commands
      do_cmd(C_SETSP, 32'h0C00); m_apply(C_SETSP, 32'h0C00); compare_all("R12 setsp");
      do_cmd(C_SETF, 32'h5);     m_apply(C_SETF, 32'h5);     compare_all("R12 setf");
      do_cmd(C_JUMP, 32'h40);    m_apply(C_JUMP, 32'h40);    compare_all("R12 jump");
      do_cmd(C_NOP, 32'hFFFF);   compare_all("R12 nop");

      // R2: directed call
      do_cmd(C_CALL, 32'h200); m_apply(C_CALL, 32'h200);
      compare_all("R2 call");
      chk("R2 saved ip", mem[32'hBFC >> 2], 32'h40);
      chk("R2 saved fp", mem[32'hBF8 >> 2], 32'h0);

      // R3: directed return
      do_cmd(C_RET, 32'h0); m_apply(C_RET, 32'h0);
      compare_all("R3 ret");

      // R10 and R11: command during a stalled call is dropped
      hold_ready = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = C_CALL; cmd_arg = 32'h300;
      @(negedge clk);
      cmd_op = C_SETF; cmd_arg = 32'hA;
      repeat (3) begin
         @(negedge clk);
         chk("R10 busy during stall", 32'(busy), 32'd1);
         chk("R11 request held", 32'(mem_req), 32'd1);
         chk("R11 push address", mem_addr, 32'h0BFC);
      end
      cmd_valid = 1'b0;
      hold_ready = 1'b0;
      while (busy) @(negedge clk);
      m_apply(C_CALL, 32'h300);
      compare_all("R10 busy command ignored");

      // R4/R5/R6: directed software interrupt and return
      do_cmd(C_INT, 32'd3); m_apply(C_INT, 32'd3);
      compare_all("R4 int entry");
      chk("R5 flag word", mem[(m_sp + 32'd8) >> 2 & 32'h3FF], 32'h15);
      do_cmd(C_RETINT, 32'd0); m_apply(C_RETINT, 32'd0);
      compare_all("R6 retint");

      // random mix (R2, R3, R4, R6, R12)
      for (int n = 0; n < 300; n++) begin
         logic [3:0]  op;
         logic [31:0] arg;
         int          sel;
         sel = int'($urandom % 10);
         case (sel)
            0: begin op = C_JUMP;  arg = $urandom & 32'hFFFF_FFFC; end
            1: begin op = C_SETSP; arg = 32'h800 + ($urandom % 256) * 4; end
            2: begin op = C_SETF;  arg = $urandom; end
            3, 4: begin op = C_CALL; arg = $urandom & 32'h0000_FFFC; end
            5: begin op = C_RET;   arg = 32'd0; end
            6: begin op = C_INT;   arg = $urandom % 8; end
            7: begin op = C_RETINT; arg = 32'd0; end
            8: begin op = C_CLI;   arg = 32'd0; end
            default: begin op = C_STI; arg = 32'd0; end
         endcase
         do_cmd(op, arg);
         m_apply(op, arg);
         if (n % 25 == 0) compare_all("R4 random sequence");
         else begin
            checks++;
            if (ip !== m_ip || sp !== m_sp || fp !== m_fp || flags !== m_fl
                || priv !== m_priv || ie !== m_ie) begin
               fails++;
               $display("FAIL R2 random op=%0d actual ip=%h sp=%h fp=%h expected ip=%h sp=%h fp=%h",
                        op, ip, sp, fp, m_ip, m_sp, m_fp);
            end
         end
      end
      mism = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== mm[i]) mism++;
      chk("R4 stack memory mismatches", 32'(mism), 32'd0);

      // R7/R8: IRQs held while disabled, lowest first, all delivered
      do_cmd(C_SETSP, 32'h0C00); m_apply(C_SETSP, 32'h0C00);
      do_cmd(C_CLI, 32'd0);      m_apply(C_CLI, 32'd0);
      irq = 8'h0A;
      @(negedge clk);
      irq = 8'h00;
      repeat (5) @(negedge clk);
      chk("R7 held while disabled busy", 32'(busy), 32'd0);
      compare_all("R7 held while disabled");
      do_cmd(C_STI, 32'd0);
      m_apply(C_STI, 32'd0);
      m_entry(16 + 1);
      compare_all("R8 irq1 entry");
      ev = 32'h4000 + 32'd17 * 32'd16;
      chk("R8 vector ip", ip, ev);
      do_cmd(C_RETINT, 32'd0);
      m_apply(C_RETINT, 32'd0);
      m_entry(16 + 3);
      compare_all("R7 second pending delivered");
      do_cmd(C_RETINT, 32'd0); m_apply(C_RETINT, 32'd0);
      compare_all("R6 back to base");

      // R9: idle wait
      while (busy) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = C_IDLE; cmd_arg = 32'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk("R9 busy while idle", 32'(busy), 32'd1);
      compare_all("R9 idle holds state");
      irq = 8'h20;
      @(negedge clk);
      irq = 8'h00;
      while (busy) @(negedge clk);
      m_entry(16 + 5);
      compare_all("R9 woken by irq5");
      do_cmd(C_RETINT, 32'd0); m_apply(C_RETINT, 32'd0);
      compare_all("R6 after idle wake");

      mism = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== mm[i]) mism++;
      chk("R4 final memory mismatches", 32'(mism), 32'd0);

      finish_run();
   end

endmodule